// File: doc/BRIEF.md
# Exception Target Level Router

This block picks the privilege level at which an incoming exception is serviced. An exception request arrives as a one-cycle strobe. With it come the level the core is running at, the security state, the exception class and the routing controls. Those controls are two bit groups: one from the secure-monitor configuration and one from the hypervisor configuration. Each group has one bit for each asynchronous class. Two presence flags say whether the hypervisor level (EL2) and the monitor level (EL3) exist in this implementation.

The decision follows a four-step privilege ladder, EL0 up to EL3. No exception is ever serviced at EL0, and none is serviced below the current level. A monitor routing bit outranks a hypervisor routing bit. A routing bit that names a level that is absent is ignored. A hypervisor routing bit is also ignored in the secure state. The result is registered and appears one cycle after the strobe, together with a one-cycle valid pulse.

Top module: `el_target_router`

## Requirements
- R1: After reset, valid_o is 0 and tgt_el_o is 1 (EL1). Levels are encoded 0..3 for EL0..EL3.
- R2: A valid result never names EL0.
- R3: A valid result is never lower than the cur_el_i presented with the strobe.
- R4: A synchronous exception (class code 0) goes to the current level, or to EL1 when the current level is EL0. No routing bit affects it.
- R5: An asynchronous exception whose own monitor bit is set goes to EL3 when has_el3_i is 1. This holds whatever its hypervisor bit is.
- R6: An asynchronous exception goes to EL2 when all of the following hold: its own hypervisor bit is set, has_el2_i is 1, secure_i is 0, and R5 does not apply. When the current level is EL3 the result is EL3.
- R7: A hypervisor bit has no effect when secure_i is 1 or has_el2_i is 0. A monitor bit has no effect when has_el3_i is 0.
- R8: Each asynchronous class reads only its own routing bit: bit 0 for IRQ, bit 1 for FIQ, bit 2 for SError. The bits of the other classes have no effect.
- R9: valid_o is 1 exactly one cycle after a cycle with req_i high. tgt_el_o changes only in that cycle and holds its value otherwise.
- R10: Class codes are 0 synchronous, 1 IRQ, 2 FIQ, 3 SError. An asynchronous exception with no effective routing bit goes to the current level, or to EL1 from EL0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Exception request strobe |
| cur_el_i | input | 2 | Current exception level |
| secure_i | input | 1 | 1 = secure state |
| exc_class_i | input | 2 | Exception class code |
| has_el2_i | input | 1 | Hypervisor level implemented |
| has_el3_i | input | 1 | Monitor level implemented |
| mon_route_i | input | 3 | Monitor routing bits, one per asynchronous class |
| hyp_route_i | input | 3 | Hypervisor routing bits, one per asynchronous class |
| valid_o | output | 1 | Result valid pulse |
| tgt_el_o | output | 2 | Target exception level |

## Verification
The hardest cases to reach are those where a routing bit must be ignored. These are a hypervisor bit in the secure state, a bit that names an absent level, and a bit that belongs to a different class. Each needs a specific mix of presence flags, security state and bit pattern at the same time. The bench therefore sweeps every combination of current level, security state, class, both presence flags and all 64 pairs of routing-bit patterns. Each case is labelled with the rule that decides it, so ignored-bit cases are counted under their own requirement.

// File: rtl/el_router_pkg.sv
package el_router_pkg;
  localparam int ELW       = 2;
  localparam int NUM_ASYNC = 3;
  localparam int CLSW      = $clog2(NUM_ASYNC + 1);

  localparam logic [ELW-1:0] LVL_EL0 = 2'd0;
  localparam logic [ELW-1:0] LVL_EL1 = 2'd1;
  localparam logic [ELW-1:0] LVL_EL2 = 2'd2;
  localparam logic [ELW-1:0] LVL_EL3 = 2'd3;

  typedef enum logic [CLSW-1:0] {
    CLS_SYNC   = 2'd0,
    CLS_IRQ    = 2'd1,
    CLS_FIQ    = 2'd2,
    CLS_SERROR = 2'd3
  } exc_class_e;
endpackage

// File: rtl/el_route_sel.sv
module el_route_sel #(
  parameter int NUM_ASYNC = el_router_pkg::NUM_ASYNC,
  parameter int CLSW      = el_router_pkg::CLSW
) (
  input  logic [CLSW-1:0]      cls_i,
  input  logic                 secure_i,
  input  logic                 has_el2_i,
  input  logic                 has_el3_i,
  input  logic [NUM_ASYNC-1:0] mon_route_i,
  input  logic [NUM_ASYNC-1:0] hyp_route_i,
  output logic                 want_el3_o,
  output logic                 want_el2_o
);
  logic [NUM_ASYNC-1:0] sel;
  logic [NUM_ASYNC-1:0] mon_hit;
  logic [NUM_ASYNC-1:0] hyp_hit;

  // async class i is encoded as code i+1
  for (genvar i = 0; i < NUM_ASYNC; i++) begin : g_cls
    assign sel[i]     = (cls_i == CLSW'(i + 1));
    assign mon_hit[i] = sel[i] & mon_route_i[i];
    assign hyp_hit[i] = sel[i] & hyp_route_i[i];
  end

  logic hyp_ok;
  assign hyp_ok     = has_el2_i & ~secure_i;
  assign want_el3_o = has_el3_i & (|mon_hit);
  assign want_el2_o = hyp_ok & (|hyp_hit) & ~want_el3_o;
endmodule

// File: rtl/el_floor.sv
module el_floor #(
  parameter int ELW = el_router_pkg::ELW
) (
  input  logic [ELW-1:0] cur_el_i,
  input  logic           want_el3_i,
  input  logic           want_el2_i,
  output logic [ELW-1:0] tgt_el_o
);
  import el_router_pkg::*;
  logic [ELW-1:0] base;
  logic [ELW-1:0] routed;

  always_comb begin
    base = (cur_el_i == LVL_EL0) ? LVL_EL1 : cur_el_i;
    if (want_el3_i)      routed = LVL_EL3;
    else if (want_el2_i) routed = LVL_EL2;
    else                 routed = LVL_EL1;
    tgt_el_o = (routed > base) ? routed : base;
  end
endmodule

// File: rtl/el_target_router.sv
module el_target_router #(
  parameter int ELW       = el_router_pkg::ELW,
  parameter int NUM_ASYNC = el_router_pkg::NUM_ASYNC,
  localparam int CLSW     = $clog2(NUM_ASYNC + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic [ELW-1:0]       cur_el_i,
  input  logic                 secure_i,
  input  logic [CLSW-1:0]      exc_class_i,
  input  logic                 has_el2_i,
  input  logic                 has_el3_i,
  input  logic [NUM_ASYNC-1:0] mon_route_i,
  input  logic [NUM_ASYNC-1:0] hyp_route_i,
  output logic                 valid_o,
  output logic [ELW-1:0]       tgt_el_o
);
  logic           want_el3;
  logic           want_el2;
  logic [ELW-1:0] tgt_d;

  el_route_sel #(.NUM_ASYNC(NUM_ASYNC), .CLSW(CLSW)) sel_i (
    .cls_i       (exc_class_i),
    .secure_i    (secure_i),
    .has_el2_i   (has_el2_i),
    .has_el3_i   (has_el3_i),
    .mon_route_i (mon_route_i),
    .hyp_route_i (hyp_route_i),
    .want_el3_o  (want_el3),
    .want_el2_o  (want_el2)
  );

  el_floor #(.ELW(ELW)) floor_i (
    .cur_el_i   (cur_el_i),
    .want_el3_i (want_el3),
    .want_el2_i (want_el2),
    .tgt_el_o   (tgt_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      tgt_el_o <= ELW'(1);
    end else begin
      valid_o <= req_i;
      if (req_i) tgt_el_o <= tgt_d;
    end
  end
endmodule

// File: rtl/el_target_router_chk.sv
module el_target_router_chk #(
  parameter int ELW  = 2,
  parameter int CLSW = 2
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_i,
  input logic [ELW-1:0]  cur_el_i,
  input logic            secure_i,
  input logic [CLSW-1:0] exc_class_i,
  input logic            valid_o,
  input logic [ELW-1:0]  tgt_el_o
);
  AST_NEVER_EL0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (tgt_el_o != '0)); // R2

  AST_NOT_BELOW_CUR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> (tgt_el_o >= $past(cur_el_i))); // R3

  AST_SYNC_LOCAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && exc_class_i == '0) |=>
      (tgt_el_o == (($past(cur_el_i) == '0) ? ELW'(1) : $past(cur_el_i)))); // R4

  AST_SECURE_NO_EL2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && secure_i && cur_el_i != ELW'(2)) |=> (tgt_el_o != ELW'(2))); // R7

  AST_VALID_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> valid_o); // R9

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !valid_o); // R9

  AST_TGT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> $stable(tgt_el_o)); // R9
endmodule

bind el_target_router el_target_router_chk #(.ELW(ELW), .CLSW(CLSW)) chk_i (.*);

// File: tb/el_target_router_tb.sv
module el_target_router_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_i = 1'b0;
  logic [1:0] cur_el_i = '0;
  logic       secure_i = 1'b0;
  logic [1:0] exc_class_i = '0;
  logic       has_el2_i = 1'b0;
  logic       has_el3_i = 1'b0;
  logic [2:0] mon_route_i = '0;
  logic [2:0] hyp_route_i = '0;
  logic       valid_o;
  logic [1:0] tgt_el_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  el_target_router dut_i (.*);

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d (cur=%0d sec=%0d cls=%0d e2=%0d e3=%0d mon=%0b hyp=%0b)",
               req, act, exp, cur_el_i, secure_i, exc_class_i, has_el2_i, has_el3_i,
               mon_route_i, hyp_route_i);
    end
  endtask

  // reference model, also returns the rule that decides the case
  function automatic int model(input int cur, input int sec, input int cls, input int e2,
                               input int e3, input int mon, input int hyp, output string tag);
    int base, r;
    bit om, oh;
    base = (cur == 0) ? 1 : cur;
    if (cls == 0) begin tag = "R4"; return base; end
    om = mon[cls-1];
    oh = hyp[cls-1];
    if (om && e3 == 1) begin tag = "R5"; r = 3; end
    else if (om || (oh && (sec == 1 || e2 == 0))) begin
      tag = "R7";
      r = (oh && sec == 0 && e2 == 1) ? 2 : 1;
    end
    else if (oh) begin tag = "R6"; r = 2; end
    else if ((mon | hyp) != 0) begin tag = "R8"; r = 1; end
    else begin tag = "R10"; r = 1; end
    return (r > base) ? r : base;
  endfunction

  initial begin
    string tag;
    int exp;
    int prev;
    @(negedge clk_i);
    check("R1 valid", int'(valid_o), 0);
    check("R1 tgt", int'(tgt_el_o), 1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 idle", int'(valid_o), 0);
    prev = 1;
    for (int cur = 0; cur < 4; cur++)
      for (int sec = 0; sec < 2; sec++)
        for (int cls = 0; cls < 4; cls++)
          for (int e2 = 0; e2 < 2; e2++)
            for (int e3 = 0; e3 < 2; e3++)
              for (int mon = 0; mon < 8; mon++)
                for (int hyp = 0; hyp < 8; hyp++) begin
                  cur_el_i = 2'(cur); secure_i = sec[0]; exc_class_i = 2'(cls);
                  has_el2_i = e2[0]; has_el3_i = e3[0];
                  mon_route_i = 3'(mon); hyp_route_i = 3'(hyp);
                  exp = model(cur, sec, cls, e2, e3, mon, hyp, tag);
                  check("R9 hold before req", int'(tgt_el_o), prev);
                  req_i = 1'b1;
                  @(negedge clk_i);
                  req_i = 1'b0;
                  check("R9 valid", int'(valid_o), 1);
                  check(tag, int'(tgt_el_o), exp);
                  total++;
                  if (tgt_el_o == 2'd0) begin bad++; $display("FAIL R2 act=0 exp=nonzero"); end
                  total++;
                  if (int'(tgt_el_o) < cur) begin
                    bad++; $display("FAIL R3 act=%0d exp>=%0d", tgt_el_o, cur);
                  end
                  // change inputs while idle: output must not move
                  cur_el_i = ~cur_el_i; exc_class_i = ~exc_class_i; mon_route_i = ~mon_route_i;
                  @(negedge clk_i);
                  check("R9 pulse", int'(valid_o), 0);
                  check("R9 hold", int'(tgt_el_o), exp);
                  prev = exp;
                end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule